// File: doc/BRIEF.md
# Cross-Channel Neighbour Sum Unit

This block prepares the denominator term of local response normalization for a stack of feature maps held as tiles of one macro-array. Each pixel needs the squared values found at its own coordinate in the maps just before and just after its own map in channel order. Normalization runs across channels, never across space. The unit takes the whole stack through a parallel load on a start pulse. Every map then sees its neighbours through whole-map shifts: one toward higher map indices and one toward lower indices for each ring of the window. The unit accumulates the squares it receives and adds a fixed bias in one closing cycle. The division and the power function that follow are not part of it.

Two shadow copies of the stack move in opposite directions. Each shift step therefore brings in a value one map further from the original than the last step of that copy did. Every channel inside the window is added exactly once, and no value is reloaded. The number of steps is set by the window width alone. A stack of any map count or map size finishes in the same number of cycles.

Top module: `xchan_sq_gather`

## Requirements
- R1: While reset is held, and directly after it, `busy` and `done` are 0 and every lane of `sum_out` is 0.
- R2: With a window of 3, each lane (map m, pixel p) ends up holding BIAS plus the squares of the pixel-p values of maps m-1, m and m+1. Element index m*MAP_PIX+p selects bits [idx*DATA_W +: DATA_W] of `in_pix` and bits [idx*(2*DATA_W+3) +: 2*DATA_W+3] of `sum_out`.
- R3: With a window of 5, each lane holds BIAS plus the squares of the pixel-p values of maps m-2 through m+2, each counted exactly once, using the same packing as R2.
- R4: A neighbour map index below 0 or above NUM_MAPS-1 contributes zero to the sum.
- R5: A start accepted while idle raises `busy` from the next cycle. `done` is a one-cycle pulse that appears exactly WIN clock edges after the accepting edge, with `busy` low in that cycle. This holds for any NUM_MAPS and MAP_PIX.
- R6: While `busy` is high, `start` and any change on `in_pix` have no effect on the result being computed or on its timing.
- R7: `sum_out` changes only in a cycle where `done` is high. Between completions it holds its value whatever `in_pix` does.
- R8: With every input at its full-scale value, the sums are exact, with no wrap: BIAS + 5*(2^DATA_W-1)^2 in the inner lanes of a 5-wide window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse; sampled only while idle |
| in_pix | input | NUM_MAPS*MAP_PIX*DATA_W | Whole tiled stack, map-major, unsigned pixels |
| busy | output | 1 | High from the cycle after launch until the result is posted |
| done | output | 1 | One-cycle pulse marking a new `sum_out` |
| sum_out | output | NUM_MAPS*MAP_PIX*(2*DATA_W+3) | Per-lane sum of squares plus bias, registered |

## Verification
Counting from the edge that accepts `start`, `busy` is due one edge later. `done` and the new sums are due WIN edges later: five for the 5-wide instance and three for the 3-wide instance. The bench drives on falling edges and samples on the falling edge after each of those rising edges. It confirms that `done` is still low one edge before the result is due and low again one edge after, and that `sum_out` does not move in later idle cycles while the inputs are changed.

// File: rtl/xsg_pkg.sv
package xsg_pkg;

   // Sequencer phases: waiting, shifting neighbours in, posting the result.
   typedef enum logic [1:0] {
      XSG_IDLE  = 2'd0,
      XSG_SHIFT = 2'd1,
      XSG_FINAL = 2'd2
   } xsg_state_e;

   // Direction of a whole-map move inside the macro-array.
   typedef enum logic {
      XSG_TOWARD_HIGH = 1'b0,
      XSG_TOWARD_LOW  = 1'b1
   } xsg_dir_e;

   // Number of shift steps needed for a window of the given width.
   function automatic int xsg_shift_steps(input int win);
      return win - 1;
   endfunction

endpackage

// File: rtl/xsg_map_shift.sv
module xsg_map_shift #(
   parameter int               NUM_MAPS = 6,
   parameter int               MAP_PIX  = 4,
   parameter int               DATA_W   = 8,
   parameter xsg_pkg::xsg_dir_e DIR     = xsg_pkg::XSG_TOWARD_HIGH
) (
   input  logic [NUM_MAPS*MAP_PIX*DATA_W-1:0] din,
   output logic [NUM_MAPS*MAP_PIX*DATA_W-1:0] dout
);
   localparam int MAP_BITS = MAP_PIX * DATA_W;

   // Each map slot takes the whole tile of its neighbour; the slot at the
   // open end of the channel order is filled with zero.
   for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
      if (DIR == xsg_pkg::XSG_TOWARD_HIGH) begin : g_hi
         if (m == 0) begin : g_edge
            assign dout[m*MAP_BITS +: MAP_BITS] = '0;
         end else begin : g_mid
            assign dout[m*MAP_BITS +: MAP_BITS] = din[(m-1)*MAP_BITS +: MAP_BITS];
         end
      end else begin : g_lo
         if (m == NUM_MAPS-1) begin : g_edge
            assign dout[m*MAP_BITS +: MAP_BITS] = '0;
         end else begin : g_mid
            assign dout[m*MAP_BITS +: MAP_BITS] = din[(m+1)*MAP_BITS +: MAP_BITS];
         end
      end
   end
endmodule

// File: rtl/xsg_sq_accum.sv
module xsg_sq_accum #(
   parameter int NUM_MAPS = 6,
   parameter int MAP_PIX  = 4,
   parameter int DATA_W   = 8,
   parameter int SUM_W    = 2*DATA_W + 3,
   parameter int BIAS     = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               load_en,
   input  logic [NUM_MAPS*MAP_PIX*DATA_W-1:0] load_vec,
   input  logic                               add_en,
   input  logic [NUM_MAPS*MAP_PIX*DATA_W-1:0] add_vec,
   input  logic                               fin_en,
   output logic [NUM_MAPS*MAP_PIX*SUM_W-1:0]  sum_out
);
   localparam int NPIX = NUM_MAPS * MAP_PIX;
   localparam int SQ_W = 2 * DATA_W;

   for (genvar e = 0; e < NPIX; e++) begin : g_lane
      logic [DATA_W-1:0] ld_val;
      logic [DATA_W-1:0] ad_val;
      logic [SQ_W-1:0]   ld_sq;
      logic [SQ_W-1:0]   ad_sq;
      logic [SUM_W-1:0]  acc_q;
      logic [SUM_W-1:0]  out_q;

      assign ld_val = load_vec[e*DATA_W +: DATA_W];
      assign ad_val = add_vec[e*DATA_W +: DATA_W];
      assign ld_sq  = {{DATA_W{1'b0}}, ld_val} * {{DATA_W{1'b0}}, ld_val};
      assign ad_sq  = {{DATA_W{1'b0}}, ad_val} * {{DATA_W{1'b0}}, ad_val};

      // Seed with the own-channel square, add one neighbour square per step,
      // post with the bias on the closing cycle.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc_q <= '0;
            out_q <= '0;
         end else begin
            if (load_en) begin
               acc_q <= SUM_W'(ld_sq);
            end else if (add_en) begin
               acc_q <= acc_q + SUM_W'(ad_sq);
            end
            if (fin_en) begin
               out_q <= acc_q + SUM_W'(BIAS);
            end
         end
      end

      assign sum_out[e*SUM_W +: SUM_W] = out_q;
   end
endmodule

// File: rtl/xsg_step_ctrl.sv
module xsg_step_ctrl #(
   parameter int WIN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load_en,
   output logic step_en,
   output logic step_toward_low,
   output logic fin_en,
   output logic busy,
   output logic done
);
   import xsg_pkg::*;

   localparam int NSHIFT = xsg_shift_steps(WIN);
   localparam int CNT_W  = $clog2(NSHIFT + 1);

   xsg_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   // Even steps move the forward copy, odd steps the backward copy.
   always_comb begin
      load_en         = (state_q == XSG_IDLE) && start;
      step_en         = (state_q == XSG_SHIFT);
      step_toward_low = cnt_q[0];
      fin_en          = (state_q == XSG_FINAL);
      busy            = (state_q != XSG_IDLE);
      done            = done_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XSG_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= (state_q == XSG_FINAL);
         case (state_q)
            XSG_IDLE: begin
               if (start) begin
                  state_q <= XSG_SHIFT;
                  cnt_q   <= '0;
               end
            end
            XSG_SHIFT: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(NSHIFT - 1)) begin
                  state_q <= XSG_FINAL;
               end
            end
            XSG_FINAL: begin
               state_q <= XSG_IDLE;
            end
            default: begin
               state_q <= XSG_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/xchan_sq_gather.sv
module xchan_sq_gather #(
   parameter int NUM_MAPS = 6,
   parameter int MAP_PIX  = 4,
   parameter int DATA_W   = 8,
   parameter int WIN      = 5,
   parameter int BIAS     = 2
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       start,
   input  logic [NUM_MAPS*MAP_PIX*DATA_W-1:0]         in_pix,
   output logic                                       busy,
   output logic                                       done,
   output logic [NUM_MAPS*MAP_PIX*(2*DATA_W+3)-1:0]   sum_out
);
   localparam int NPIX  = NUM_MAPS * MAP_PIX;
   localparam int VEC_W = NPIX * DATA_W;
   localparam int SUM_W = 2*DATA_W + 3;

   // Elaboration-time parameter checks.
   if (!(WIN == 3 || WIN == 5)) begin : g_bad_win
      $error("xchan_sq_gather: WIN must be 3 or 5");
   end
   if (NUM_MAPS < 2 || MAP_PIX < 1 || DATA_W < 1) begin : g_bad_shape
      $error("xchan_sq_gather: stack shape out of range");
   end
   if (BIAS < 0 || BIAS >= (1 << (2*DATA_W))) begin : g_bad_bias
      $error("xchan_sq_gather: BIAS must fit in 2*DATA_W bits");
   end

   logic load_en;
   logic step_en;
   logic step_toward_low;
   logic fin_en;

   logic [VEC_W-1:0] fwd_q;
   logic [VEC_W-1:0] bwd_q;
   logic [VEC_W-1:0] fwd_nx;
   logic [VEC_W-1:0] bwd_nx;
   logic [VEC_W-1:0] add_vec;

   xsg_step_ctrl #(
      .WIN (WIN)
   ) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .start           (start),
      .load_en         (load_en),
      .step_en         (step_en),
      .step_toward_low (step_toward_low),
      .fin_en          (fin_en),
      .busy            (busy),
      .done            (done)
   );

   xsg_map_shift #(
      .NUM_MAPS (NUM_MAPS),
      .MAP_PIX  (MAP_PIX),
      .DATA_W   (DATA_W),
      .DIR      (xsg_pkg::XSG_TOWARD_HIGH)
   ) u_shift_hi (
      .din  (fwd_q),
      .dout (fwd_nx)
   );

   xsg_map_shift #(
      .NUM_MAPS (NUM_MAPS),
      .MAP_PIX  (MAP_PIX),
      .DATA_W   (DATA_W),
      .DIR      (xsg_pkg::XSG_TOWARD_LOW)
   ) u_shift_lo (
      .din  (bwd_q),
      .dout (bwd_nx)
   );

   // Two travelling copies of the stack: each move takes them one map
   // further from home, so ring k of the window arrives on the k-th move.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_q <= '0;
         bwd_q <= '0;
      end else if (load_en) begin
         fwd_q <= in_pix;
         bwd_q <= in_pix;
      end else if (step_en) begin
         if (step_toward_low) begin
            bwd_q <= bwd_nx;
         end else begin
            fwd_q <= fwd_nx;
         end
      end
   end

   assign add_vec = step_toward_low ? bwd_nx : fwd_nx;

   xsg_sq_accum #(
      .NUM_MAPS (NUM_MAPS),
      .MAP_PIX  (MAP_PIX),
      .DATA_W   (DATA_W),
      .SUM_W    (SUM_W),
      .BIAS     (BIAS)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .load_vec (in_pix),
      .add_en   (step_en),
      .add_vec  (add_vec),
      .fin_en   (fin_en),
      .sum_out  (sum_out)
   );
endmodule

// File: rtl/xsg_checker.sv
module xsg_checker #(
   parameter int WIN   = 5,
   parameter int OUT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [OUT_W-1:0] sum_out
);
   // Edges seen since the accepting edge of the current operation.
   logic [3:0] lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q <= '0;
      end else if (start && !busy) begin
         lat_q <= '0;
      end else if (busy) begin
         lat_q <= lat_q + 4'd1;
      end
   end

   assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == 4'(WIN)));

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_idle_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sum_out) |-> done);
endmodule

bind xchan_sq_gather xsg_checker #(
   .WIN   (WIN),
   .OUT_W (NUM_MAPS*MAP_PIX*(2*DATA_W+3))
) u_xsg_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .sum_out (sum_out)
);

// File: tb/xchan_sq_gather_bench.sv
`timescale 1ns/1ps
module xchan_sq_gather_bench;
   localparam int DW     = 8;
   localparam int SW     = 2*DW + 3;
   localparam int MAPS_A = 6;
   localparam int PIX_A  = 4;
   localparam int WIN_A  = 5;
   localparam int BIAS_A = 2;
   localparam int MAPS_B = 5;
   localparam int PIX_B  = 3;
   localparam int WIN_B  = 3;
   localparam int BIAS_B = 7;
   localparam int VEC_A  = MAPS_A*PIX_A*DW;
   localparam int OUT_A  = MAPS_A*PIX_A*SW;
   localparam int VEC_B  = MAPS_B*PIX_B*DW;
   localparam int OUT_B  = MAPS_B*PIX_B*SW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_a = 1'b0;
   logic start_b = 1'b0;
   logic [VEC_A-1:0] din_a = '0;
   logic [VEC_B-1:0] din_b = '0;
   logic busy_a, done_a, busy_b, done_b;
   logic [OUT_A-1:0] sum_a;
   logic [OUT_B-1:0] sum_b;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   xchan_sq_gather #(
      .NUM_MAPS (MAPS_A), .MAP_PIX (PIX_A), .DATA_W (DW), .WIN (WIN_A), .BIAS (BIAS_A)
   ) u_xchan_sq_gather (
      .clk (clk), .rst_n (rst_n), .start (start_a), .in_pix (din_a),
      .busy (busy_a), .done (done_a), .sum_out (sum_a)
   );

   xchan_sq_gather #(
      .NUM_MAPS (MAPS_B), .MAP_PIX (PIX_B), .DATA_W (DW), .WIN (WIN_B), .BIAS (BIAS_B)
   ) u_xchan_sq_gather_w3 (
      .clk (clk), .rst_n (rst_n), .start (start_b), .in_pix (din_b),
      .busy (busy_b), .done (done_b), .sum_out (sum_b)
   );

   function automatic logic [OUT_A-1:0] expect_sums(input logic [VEC_A-1:0] d,
                                                     input int nm, input int np,
                                                     input int half, input int bias);
      logic [OUT_A-1:0] r = '0;
      for (int m = 0; m < nm; m++) begin
         for (int p = 0; p < np; p++) begin
            int s = bias;
            for (int o = -half; o <= half; o++) begin
               int mm = m + o;
               if (mm >= 0 && mm < nm) begin
                  int v = int'(d[(mm*np+p)*DW +: DW]);
                  s = s + v*v;
               end
            end
            r[(m*np+p)*SW +: SW] = s[SW-1:0];
         end
      end
      return r;
   endfunction

   task automatic check_vec(input string req, input logic [OUT_A-1:0] act,
                            input logic [OUT_A-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s sums actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input string what,
                            input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic run_a(input logic [VEC_A-1:0] d, input bit poke, input string req);
      logic [OUT_A-1:0] exp = expect_sums(d, MAPS_A, PIX_A, 2, BIAS_A);
      @(negedge clk);
      din_a   = d;
      start_a = 1'b1;
      @(negedge clk);                 // accepting edge has passed
      start_a = 1'b0;
      check_bit("R5", "busy after launch", busy_a, 1'b1);
      if (poke) begin                 // R6: stray start and new data while busy
         start_a = 1'b1;
         din_a   = ~d;
      end
      for (int i = 1; i < WIN_A; i++) begin
         @(negedge clk);
         start_a = 1'b0;
      end
      check_bit("R5", "done early", done_a, 1'b0);
      @(negedge clk);
      check_bit("R5", "done on time", done_a, 1'b1);
      check_bit("R5", "busy at done", busy_a, 1'b0);
      check_vec(poke ? "R6" : req, sum_a, exp);
      din_a = d ^ VEC_A'({$urandom, $urandom});
      @(negedge clk);
      check_bit("R5", "done single pulse", done_a, 1'b0);
      repeat (2) @(negedge clk);
      check_vec("R7", sum_a, exp);
   endtask

   task automatic run_b(input logic [VEC_B-1:0] d, input bit poke, input string req);
      logic [OUT_A-1:0] exp = expect_sums(VEC_A'(d), MAPS_B, PIX_B, 1, BIAS_B);
      @(negedge clk);
      din_b   = d;
      start_b = 1'b1;
      @(negedge clk);
      start_b = 1'b0;
      check_bit("R5", "busy after launch w3", busy_b, 1'b1);
      if (poke) begin
         start_b = 1'b1;
         din_b   = ~d;
      end
      for (int i = 1; i < WIN_B; i++) begin
         @(negedge clk);
         start_b = 1'b0;
      end
      check_bit("R5", "done early w3", done_b, 1'b0);
      @(negedge clk);
      check_bit("R5", "done on time w3", done_b, 1'b1);
      check_vec(poke ? "R6" : req, OUT_A'(sum_b), exp);
      din_b = ~din_b;
      @(negedge clk);
      check_bit("R5", "done single pulse w3", done_b, 1'b0);
      repeat (2) @(negedge clk);
      check_vec("R7", OUT_A'(sum_b), exp);
   endtask

   task automatic print_summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         print_summary();
         $finish;
      end
   end

   initial begin : main
      logic [VEC_A-1:0] va;
      logic [VEC_B-1:0] vb;
      void'($urandom(32'd2718));

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_bit("R1", "busy in reset", busy_a, 1'b0);
      check_bit("R1", "done in reset", done_a, 1'b0);
      check_vec("R1", sum_a, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1", "busy after reset", busy_b, 1'b0);
      check_vec("R1", OUT_A'(sum_b), '0);

      // Directed corners
      run_a('0, 1'b0, "R3");                       // bias only
      run_a({VEC_A{1'b1}}, 1'b0, "R8");            // full scale, no wrap
      run_b({VEC_B{1'b1}}, 1'b0, "R8");
      va = '0;                                     // R4: only the first map loaded
      for (int p = 0; p < PIX_A; p++) va[p*DW +: DW] = 8'(200 + p);
      run_a(va, 1'b0, "R4");
      va = '0;                                     // R4: only the last map loaded
      for (int p = 0; p < PIX_A; p++) va[((MAPS_A-1)*PIX_A+p)*DW +: DW] = 8'(17 * (p+1));
      run_a(va, 1'b0, "R4");
      vb = '0;
      for (int p = 0; p < PIX_B; p++) vb[p*DW +: DW] = 8'(90 + p);
      run_b(vb, 1'b0, "R4");

      // Random patterns, some with stray start and data while busy (R6)
      for (int n = 0; n < 20; n++) begin
         for (int e = 0; e < MAPS_A*PIX_A; e++) va[e*DW +: DW] = 8'($urandom);
         run_a(va, (n % 4) == 3, "R3");
      end
      for (int n = 0; n < 12; n++) begin
         for (int e = 0; e < MAPS_B*PIX_B; e++) vb[e*DW +: DW] = 8'($urandom);
         run_b(vb, (n % 3) == 2, "R2");
      end

      finished = 1'b1;
      print_summary();
      $finish;
   end
endmodule